// File: doc/BRIEF.md
# Cartridge Bank Address Translator

This block holds the four 5-bit control words of a serially programmed cartridge bank controller. From them it turns the CPU and picture-bus addresses into physical locations in program ROM, work RAM and character pattern memory, and it picks the nametable half. A serial loader that sits outside this block assembles each 5-bit word. The loader hands the finished word over as a parallel write, and it raises a restore pulse when it sees its reset command.

All translation is combinational from registered state. A write therefore affects the address outputs from the cycle after the edge that captures it.

The pattern words have two more uses on large boards. With a 512 KB program ROM, bit 4 of the pattern word written last becomes bank bit 4 in every program window. Bits 4:3 of that word, or bit 3 alone on a 512 KB board, also pick the work-RAM bank. Every bank number is cut to the configured memory size, so a value beyond that size wraps.

Top module: `cart_bank_xlat`

## Requirements
- R1: After reset, control word 0 reads 0x0C and words 1 to 3 read 0. The high program bit and the stored pattern source word are 0. So 0x8000 maps to bank 0, 0xC000 maps to bank 0xF, and work RAM is enabled.
- R2: When cfg_wr_en is high and mode_restore is low, cfg_wr_data is loaded into word cfg_wr_idx at the clock edge. Index 0 is control, 1 is pattern-low, 2 is pattern-high and 3 is program. Outputs reflect the new value from the next cycle.
- R3: Control bits 1:0 set nt_a10 from ppu_addr. 0 gives a constant 0, 1 gives a constant 1, 2 gives ppu_addr[10] (vertical) and 3 gives ppu_addr[11] (horizontal).
- R4: With control bit 3 at 0, the 16 KB bank is {hi, prog[3:1], cpu_addr[14]}. This makes one 32 KB bank across 0x8000-0xFFFF.
- R5: With control bits 3:2 at 11, the window at 0x8000 takes {hi, prog[3:0]} and the window at 0xC000 takes {hi, 0xF}.
- R6: With control bits 3:2 at 10, the window at 0x8000 takes {hi, 0x0} and the window at 0xC000 takes {hi, prog[3:0]}.
- R7: With control bit 4 at 0, the 4 KB pattern bank is {pat_lo[4:1], ppu_addr[12]}, which gives one 8 KB bank.
- R8: With control bit 4 at 1, pattern-low selects the 4 KB bank at 0x0000 and pattern-high selects the 4 KB bank at 0x1000.
- R9: prog_ram_cs is high exactly when cpu_addr is in 0x6000-0x7FFF and program word bit 4 is 0.
- R10: With PROG_BANK_BITS = 5, hi equals bit 4 of the pattern word written last (index 1 or 2). With fewer bank bits, hi is always 0.
- R11: The RAM bank comes from the pattern word written last. It is bits 4:3 of that word, or only bit 3 when PROG_BANK_BITS = 5. The result is masked by RAM_BANKS-1, and prog_ram_addr = {bank, cpu_addr[12:0]}.
- R12: mode_restore sets control bits 3:2 and keeps control bits 4 and 1:0. A write in the same cycle is discarded.
- R13: Program and pattern bank numbers keep only their low PROG_BANK_BITS and PAT_BANK_BITS bits, so larger values wrap.
- R14: prog_rom_cs equals cpu_addr[15], and prog_rom_addr = {bank, cpu_addr[13:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Load a finished control word |
| cfg_wr_idx | input | 2 | Target word index |
| cfg_wr_data | input | 5 | Word value |
| mode_restore | input | 1 | Force the 16 KB fixed-high program mode |
| cpu_addr | input | 16 | CPU address |
| prog_rom_addr | output | 14+PROG_BANK_BITS | Physical program ROM address |
| prog_rom_cs | output | 1 | Program ROM selected |
| prog_ram_addr | output | 15 | Physical work RAM address |
| prog_ram_cs | output | 1 | Work RAM selected |
| ppu_addr | input | 14 | Picture-bus address |
| pat_addr | output | 12+PAT_BANK_BITS | Physical pattern memory address |
| nt_a10 | output | 1 | Nametable half select |

## Verification
A word write and a restore pulse can arrive in the same cycle. The bench also makes a pattern-word write fall in a cycle whose program address is being translated, so the high bit changes under a live window. Both instances, the 512 KB one and the smaller one, are driven with directed collisions where restore and a write to word 3 coincide. They also get random traffic that raises both controls together at random. The behavioural model gives precedence to restore and sees the new high bit only from the next cycle. It judges every output on every cycle.

// File: rtl/cbx_pkg.sv
package cbx_pkg;
  localparam int CFG_W   = 5;
  localparam int NUM_CFG = 4;

  typedef logic [CFG_W-1:0] cfg_t;

  // word indices
  localparam logic [1:0] IDX_CTRL   = 2'd0;
  localparam logic [1:0] IDX_PAT_LO = 2'd1;
  localparam logic [1:0] IDX_PAT_HI = 2'd2;
  localparam logic [1:0] IDX_PROG   = 2'd3;

  // control field positions
  localparam int CTRL_PAT4K_BIT  = 4;
  localparam int CTRL_PROG16_BIT = 3;
  localparam int CTRL_SLOT_BIT   = 2;
  localparam int PROG_RAMOFF_BIT = 4;

  localparam cfg_t CTRL_RESET   = 5'h0C;
  localparam cfg_t RESTORE_MASK = 5'h0C;

  typedef enum logic [1:0] {
    NT_SINGLE_LO = 2'd0,
    NT_SINGLE_HI = 2'd1,
    NT_VERT      = 2'd2,
    NT_HORZ      = 2'd3
  } nt_mode_e;

  typedef enum logic [1:0] {
    PM_WIDE      = 2'd0,
    PM_SWAP_LOW  = 2'd1,
    PM_SWAP_HIGH = 2'd2
  } prog_mode_e;

  function automatic prog_mode_e prog_mode(input cfg_t ctrl);
    if (!ctrl[CTRL_PROG16_BIT])   return PM_WIDE;
    else if (ctrl[CTRL_SLOT_BIT]) return PM_SWAP_LOW;
    else                          return PM_SWAP_HIGH;
  endfunction
endpackage

// File: rtl/cbx_rst_sync.sv
module cbx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/cbx_cfg_regs.sv
module cbx_cfg_regs
  import cbx_pkg::*;
#(
  parameter bit EXT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [1:0]             wr_idx,
  input  cfg_t                   wr_data,
  input  logic                   restore,
  output cfg_t [NUM_CFG-1:0]     cfg_q,
  output logic                   hi_q,
  output cfg_t                   src_q
);
  logic wr_ok;
  logic pat_wr;
  logic side_en;
  logic hi_d;
  cfg_t src_d;

  assign wr_ok  = wr_en && !restore;
  assign pat_wr = wr_ok && ((wr_idx == IDX_PAT_LO) || (wr_idx == IDX_PAT_HI));

  // one register per control word, each with its own load enable
  for (genvar g = 0; g < NUM_CFG; g++) begin : g_word
    localparam cfg_t RST_VAL = (g == 0) ? CTRL_RESET : '0;
    logic ld_en;
    cfg_t word_d;

    always_comb begin
      ld_en  = 1'b0;
      word_d = cfg_q[g];
      if (restore && (g == 0)) begin
        ld_en  = 1'b1;
        word_d = cfg_q[g] | RESTORE_MASK;
      end else if (wr_ok && (wr_idx == 2'(g))) begin
        ld_en  = 1'b1;
        word_d = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cfg_q[g] <= RST_VAL;
      else if (ld_en) cfg_q[g] <= word_d;
    end
  end

  // side state taken from the last pattern write
  always_comb begin
    side_en = pat_wr;
    src_d   = wr_data;
    hi_d    = EXT ? wr_data[CFG_W-1] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= 1'b0;
      src_q <= '0;
    end else if (side_en) begin
      hi_q  <= hi_d;
      src_q <= src_d;
    end
  end
endmodule

// File: rtl/cbx_prog_map.sv
module cbx_prog_map
  import cbx_pkg::*;
#(
  parameter int PB        = 5,
  parameter int RAM_BANKS = 4,
  parameter bit EXT       = 1'b1,
  localparam int PA_W     = 14 + PB
) (
  input  cfg_t              ctrl,
  input  cfg_t              prog_sel,
  input  logic              hi,
  input  cfg_t              ram_src,
  input  logic [15:0]       cpu_addr,
  output logic [PA_W-1:0]   rom_addr,
  output logic              rom_cs,
  output logic [14:0]       ram_addr,
  output logic              ram_cs
);
  localparam logic [1:0] RAM_MASK = 2'(RAM_BANKS - 1);

  logic       win;
  logic [3:0] nib;
  logic [4:0] bank_full;
  logic [1:0] ram_raw;
  logic [1:0] ram_sel;

  assign win = cpu_addr[14];
  assign nib = prog_sel[3:0];

  always_comb begin
    unique case (prog_mode(ctrl))
      PM_WIDE:      bank_full = {hi, nib[3:1], win};
      PM_SWAP_LOW:  bank_full = win ? {hi, 4'hF} : {hi, nib};
      PM_SWAP_HIGH: bank_full = win ? {hi, nib}  : {hi, 4'h0};
      default:      bank_full = {hi, nib};
    endcase
  end

  assign rom_addr = {bank_full[PB-1:0], cpu_addr[13:0]};
  assign rom_cs   = cpu_addr[15];

  if (EXT) begin : g_ram_ext
    assign ram_raw = {1'b0, ram_src[3]};
  end else begin : g_ram_std
    assign ram_raw = ram_src[4:3];
  end

  assign ram_sel  = ram_raw & RAM_MASK;
  assign ram_addr = {ram_sel, cpu_addr[12:0]};
  assign ram_cs   = !prog_sel[PROG_RAMOFF_BIT] && (cpu_addr[15:13] == 3'b011);
endmodule

// File: rtl/cbx_pat_map.sv
module cbx_pat_map
  import cbx_pkg::*;
#(
  parameter int CB    = 5,
  localparam int PT_W = 12 + CB
) (
  input  cfg_t              ctrl,
  input  cfg_t              lo_sel,
  input  cfg_t              hi_sel,
  input  logic [13:0]       ppu_addr,
  output logic [PT_W-1:0]   pat_addr,
  output logic              nt_a10
);
  logic win;
  cfg_t bank_full;

  assign win = ppu_addr[12];

  always_comb begin
    if (ctrl[CTRL_PAT4K_BIT]) bank_full = win ? hi_sel : lo_sel;
    else                      bank_full = {lo_sel[4:1], win};
  end

  assign pat_addr = {bank_full[CB-1:0], ppu_addr[11:0]};

  always_comb begin
    unique case (nt_mode_e'(ctrl[1:0]))
      NT_SINGLE_LO: nt_a10 = 1'b0;
      NT_SINGLE_HI: nt_a10 = 1'b1;
      NT_VERT:      nt_a10 = ppu_addr[10];
      NT_HORZ:      nt_a10 = ppu_addr[11];
      default:      nt_a10 = 1'b0;
    endcase
  end
endmodule

// File: rtl/cart_bank_xlat.sv
module cart_bank_xlat
  import cbx_pkg::*;
#(
  parameter int PROG_BANK_BITS = 5,
  parameter int PAT_BANK_BITS  = 5,
  parameter int RAM_BANKS      = 4,
  localparam int PROG_ADDR_W   = 14 + PROG_BANK_BITS,
  localparam int PAT_ADDR_W    = 12 + PAT_BANK_BITS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr_en,
  input  logic [1:0]             cfg_wr_idx,
  input  logic [4:0]             cfg_wr_data,
  input  logic                   mode_restore,
  input  logic [15:0]            cpu_addr,
  output logic [PROG_ADDR_W-1:0] prog_rom_addr,
  output logic                   prog_rom_cs,
  output logic [14:0]            prog_ram_addr,
  output logic                   prog_ram_cs,
  input  logic [13:0]            ppu_addr,
  output logic [PAT_ADDR_W-1:0]  pat_addr,
  output logic                   nt_a10
);
  localparam bit EXT_PROG = (PROG_BANK_BITS == 5);

  logic               rst_n_sync;
  cfg_t [NUM_CFG-1:0] cfg_q;
  logic               hi_q;
  cfg_t               src_q;

  cbx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  cbx_cfg_regs #(.EXT(EXT_PROG)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (cfg_wr_en),
    .wr_idx  (cfg_wr_idx),
    .wr_data (cfg_wr_data),
    .restore (mode_restore),
    .cfg_q   (cfg_q),
    .hi_q    (hi_q),
    .src_q   (src_q)
  );

  cbx_prog_map #(.PB(PROG_BANK_BITS), .RAM_BANKS(RAM_BANKS), .EXT(EXT_PROG)) u_prog (
    .ctrl     (cfg_q[IDX_CTRL]),
    .prog_sel (cfg_q[IDX_PROG]),
    .hi       (hi_q),
    .ram_src  (src_q),
    .cpu_addr (cpu_addr),
    .rom_addr (prog_rom_addr),
    .rom_cs   (prog_rom_cs),
    .ram_addr (prog_ram_addr),
    .ram_cs   (prog_ram_cs)
  );

  cbx_pat_map #(.CB(PAT_BANK_BITS)) u_pat (
    .ctrl     (cfg_q[IDX_CTRL]),
    .lo_sel   (cfg_q[IDX_PAT_LO]),
    .hi_sel   (cfg_q[IDX_PAT_HI]),
    .ppu_addr (ppu_addr),
    .pat_addr (pat_addr),
    .nt_a10   (nt_a10)
  );
endmodule

// File: rtl/cbx_checker.sv
module cbx_checker
  import cbx_pkg::*;
#(
  parameter int PB  = 5,
  parameter bit EXT = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input cfg_t [NUM_CFG-1:0] cfg_q,
  input logic               hi_q,
  input logic               wr_en,
  input logic [1:0]         wr_idx,
  input cfg_t               wr_data,
  input logic               restore,
  input logic [15:0]        cpu_addr,
  input logic [14+PB-1:0]   prog_rom_addr,
  input logic               prog_ram_cs,
  input logic               nt_a10
);
  // R2
  word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !restore) |=> cfg_q[$past(wr_idx)] == $past(wr_data));

  // R12
  restore_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> (cfg_q[0][3:2] == 2'b11) && (cfg_q[0][4] == $past(cfg_q[0][4]))
                && (cfg_q[0][1:0] == $past(cfg_q[0][1:0])));

  // R12
  restore_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> (cfg_q[3] == $past(cfg_q[3])) && (cfg_q[2] == $past(cfg_q[2]))
                && (cfg_q[1] == $past(cfg_q[1])));

  // R9
  ram_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[3][4] |-> !prog_ram_cs);

  // R3
  nt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[0][1:0] == 2'b01) |-> nt_a10);

  // R5
  fixed_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_q[0][3:2] == 2'b11) && cpu_addr[14])
      |-> prog_rom_addr[14+PB-1:14] == PB'({hi_q, 4'hF}));

  if (EXT) begin : g_hi_ext
    // R10
    hi_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !restore && ((wr_idx == 2'd1) || (wr_idx == 2'd2)))
        |=> hi_q == $past(wr_data[4]));
  end else begin : g_hi_std
    // R10
    hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !hi_q);
  end
endmodule

bind cart_bank_xlat cbx_checker #(.PB(PROG_BANK_BITS), .EXT(EXT_PROG)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n_sync),
  .cfg_q         (cfg_q),
  .hi_q          (hi_q),
  .wr_en         (cfg_wr_en),
  .wr_idx        (cfg_wr_idx),
  .wr_data       (cfg_wr_data),
  .restore       (mode_restore),
  .cpu_addr      (cpu_addr),
  .prog_rom_addr (prog_rom_addr),
  .prog_ram_cs   (prog_ram_cs),
  .nt_a10        (nt_a10)
);

// File: tb/sim_cart_bank_xlat.sv
`timescale 1ns/1ps
module sim_cart_bank_xlat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = 2'd0;
  logic [4:0]  wr_data = 5'd0;
  logic        restore = 1'b0;
  logic [15:0] cpu = 16'h0000;
  logic [13:0] ppu = 14'h0000;

  always #10 clk = ~clk;

  // u0: 512 KB program, 64 KB pattern, 4 RAM banks
  logic [18:0] a_rom;  logic a_rom_cs;  logic [14:0] a_ram;  logic a_ram_cs;
  logic [15:0] a_pat;  logic a_nt;
  // u1: 256 KB program, 128 KB pattern, 2 RAM banks
  logic [17:0] b_rom;  logic b_rom_cs;  logic [14:0] b_ram;  logic b_ram_cs;
  logic [16:0] b_pat;  logic b_nt;

  cart_bank_xlat #(.PROG_BANK_BITS(5), .PAT_BANK_BITS(4), .RAM_BANKS(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_en), .cfg_wr_idx(wr_idx),
    .cfg_wr_data(wr_data), .mode_restore(restore), .cpu_addr(cpu),
    .prog_rom_addr(a_rom), .prog_rom_cs(a_rom_cs), .prog_ram_addr(a_ram),
    .prog_ram_cs(a_ram_cs), .ppu_addr(ppu), .pat_addr(a_pat), .nt_a10(a_nt));

  cart_bank_xlat #(.PROG_BANK_BITS(4), .PAT_BANK_BITS(5), .RAM_BANKS(2)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_en), .cfg_wr_idx(wr_idx),
    .cfg_wr_data(wr_data), .mode_restore(restore), .cpu_addr(cpu),
    .prog_rom_addr(b_rom), .prog_rom_cs(b_rom_cs), .prog_ram_addr(b_ram),
    .prog_ram_cs(b_ram_cs), .ppu_addr(ppu), .pat_addr(b_pat), .nt_a10(b_nt));

  // behavioural model state
  int    m_cfg [4];
  int    m_last;      // value of the last pattern-word write
  int    total = 0;
  int    fails = 0;
  string cur_req = "R1";

  function automatic int exp_rom(int a, int pb, bit ext);
    int hi, nib, win, b;
    hi  = ext ? (m_last / 16) % 2 : 0;
    nib = m_cfg[3] % 16;
    win = (a / 16384) % 2;
    if ((m_cfg[0] / 8) % 2 == 0)      b = ((nib + 16*hi) / 2) * 2 + win;
    else if ((m_cfg[0] / 4) % 2 == 1) b = win ? 15 + 16*hi : nib + 16*hi;
    else                              b = win ? nib + 16*hi : 16*hi;
    b = b % (1 << pb);
    return b * 16384 + a % 16384;
  endfunction

  function automatic int exp_ram(int a, int banks, bit ext);
    int s;
    s = ext ? (m_last / 8) % 2 : (m_last / 8) % 4;
    s = s % banks;
    return s * 8192 + a % 8192;
  endfunction

  function automatic int exp_ram_cs(int a);
    return (m_cfg[3] < 16 && a >= 'h6000 && a < 'h8000) ? 1 : 0;
  endfunction

  function automatic int exp_pat(int p, int cb);
    int win, b;
    win = (p / 4096) % 2;
    if ((m_cfg[0] / 16) % 2 == 1) b = win ? m_cfg[2] : m_cfg[1];
    else                          b = (m_cfg[1] / 2) * 2 + win;
    b = b % (1 << cb);
    return b * 4096 + p % 4096;
  endfunction

  function automatic int exp_nt(int p);
    case (m_cfg[0] % 4)
      0: return 0;
      1: return 1;
      2: return (p / 1024) % 2;
      default: return (p / 2048) % 2;
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int a, p;
    a = int'(cpu);
    p = int'(ppu);
    chk(cur_req, "u0 rom addr", int'(a_rom), exp_rom(a, 5, 1'b1));
    chk(cur_req, "u1 rom addr", int'(b_rom), exp_rom(a, 4, 1'b0));
    chk("R14", "u0 rom cs", int'(a_rom_cs), a >= 'h8000 ? 1 : 0);
    chk("R14", "u1 rom cs", int'(b_rom_cs), a >= 'h8000 ? 1 : 0);
    chk("R11", "u0 ram addr", int'(a_ram), exp_ram(a, 4, 1'b1));
    chk("R11", "u1 ram addr", int'(b_ram), exp_ram(a, 2, 1'b0));
    chk("R9", "u0 ram cs", int'(a_ram_cs), exp_ram_cs(a));
    chk("R9", "u1 ram cs", int'(b_ram_cs), exp_ram_cs(a));
    chk(cur_req, "u0 pat addr", int'(a_pat), exp_pat(p, 4));
    chk(cur_req, "u1 pat addr", int'(b_pat), exp_pat(p, 5));
    chk("R3", "u0 nt", int'(a_nt), exp_nt(p));
    chk("R3", "u1 nt", int'(b_nt), exp_nt(p));
  endtask

  // compare, take the edge, update the model, return at the falling edge
  task automatic tick();
    #2;
    compare_all();
    @(posedge clk);
    if (restore) begin
      if ((m_cfg[0] / 4) % 4 != 3) m_cfg[0] = (m_cfg[0] / 16) * 16 + 12 + m_cfg[0] % 4;
    end else if (wr_en) begin
      m_cfg[wr_idx] = int'(wr_data);
      if (wr_idx == 2'd1 || wr_idx == 2'd2) m_last = int'(wr_data);
    end
    @(negedge clk);
  endtask

  task automatic put(input logic [1:0] idx, input logic [4:0] val);
    wr_en = 1'b1; wr_idx = idx; wr_data = val;
    tick();
    wr_en = 1'b0;
  endtask

  logic [15:0] CPU_PTS [8] = '{16'h5FFF, 16'h6000, 16'h7FFF, 16'h8000,
                               16'hBFFF, 16'hC000, 16'hE123, 16'hFFFF};
  logic [13:0] PPU_PTS [8] = '{14'h0000, 14'h0FFF, 14'h1000, 14'h1ABC,
                               14'h2000, 14'h2400, 14'h2800, 14'h2C00};

  task automatic sweep();
    for (int i = 0; i < 8; i++) begin
      cpu = CPU_PTS[i];
      ppu = PPU_PTS[i];
      tick();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL R2 watchdog: actual 200000 cycles expected completion earlier");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    m_cfg[0] = 12; m_cfg[1] = 0; m_cfg[2] = 0; m_cfg[3] = 0;
    m_last = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    cur_req = "R1";  sweep();
    cur_req = "R2";  put(2'd3, 5'h05); sweep();
    cur_req = "R5";  put(2'd3, 5'h09); sweep();
    cur_req = "R3";
    for (int m = 0; m < 4; m++) begin
      put(2'd0, 5'(12 + m));
      sweep();
    end
    cur_req = "R4";  put(2'd0, 5'h02); put(2'd3, 5'h07); sweep();
    cur_req = "R6";  put(2'd0, 5'h0B); put(2'd3, 5'h06); sweep();
    cur_req = "R7";  put(2'd1, 5'h13); put(2'd2, 5'h0A); sweep();
    cur_req = "R8";  put(2'd0, 5'h1B); sweep();
    cur_req = "R13"; put(2'd1, 5'h1F); put(2'd2, 5'h15); sweep();
    cur_req = "R9";  put(2'd3, 5'h12); sweep(); put(2'd3, 5'h02); sweep();
    // R10: high bit arrives through a pattern write while a window is live
    cur_req = "R10"; cpu = 16'hC000; put(2'd1, 5'h10); sweep();
    put(2'd0, 5'h0E); sweep(); put(2'd0, 5'h02); sweep();
    put(2'd2, 5'h0F); sweep();
    cur_req = "R11"; put(2'd2, 5'h18); sweep(); put(2'd1, 5'h10); sweep();
    put(2'd1, 5'h08); sweep();
    // R12: restore alone, then restore colliding with a program write
    cur_req = "R12"; put(2'd0, 5'h11);
    restore = 1'b1; tick(); restore = 1'b0; sweep();
    put(2'd0, 5'h02);
    restore = 1'b1; wr_en = 1'b1; wr_idx = 2'd3; wr_data = 5'h1D; tick();
    restore = 1'b0; wr_en = 1'b0; sweep();

    for (int n = 0; n < 3000; n++) begin
      wr_en   = ($urandom % 3) == 0;
      wr_idx  = 2'($urandom % 4);
      wr_data = 5'($urandom % 32);
      restore = ($urandom % 12) == 0;
      cpu     = 16'($urandom % 65536);
      ppu     = 14'($urandom % 16384);
      cur_req = (restore && wr_en) ? "R12" : "R2";
      tick();
    end
    wr_en = 1'b0; restore = 1'b0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule